// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block sits beside a small 8-bit CPU core and decides when the core should leave its program to run an interrupt handler, and which handler. It watches a parameterized set of interrupt sources. Each source is fixed at build time as either an event source, whose rising edge is caught in a sticky flag, or a level source, which asks for service only while its input is high. Software controls one enable bit per source, a global enable bit, and clears flags by writing ones.

When an enabled source is pending and the global enable is set, the controller picks the source with the lowest vector index, drives a registered request with that index and its vector address, and clears the global enable. The request stays up until the core acknowledges it. The core also reports return-from-interrupt and instruction-retired events. After a return, the controller lets one instruction of the interrupted program finish before it raises the next request. A disable strobe blocks acceptance in the same cycle that it arrives. A select input places the vector table either at address zero or at a boot-section base.

Top module: `irqv_ctrl`

## Requirements
- R1: While reset is low and in the first cycle after it, `irq_req`, `gie_o` and every bit of `flags_o` are 0, and all source enables are 0.
- R2: A source is accepted only when its enable bit (loaded from `en_wdata` on a cycle with `en_wr` high) and the global enable are both 1.
- R3: Source k (bit k of `src_i`) has vector index k+1; index 0 belongs to reset and is never issued. When several eligible sources are pending, the lowest index is accepted.
- R4: Accepting a source clears the global enable. `sei` or `cpu_reti` sets it. `cli` clears it. If `cli` arrives with either of the setting strobes, `cli` wins. Acceptance wins over `sei`.
- R5: An event source whose input goes from 0 to 1 sets its flag one cycle later, even while it is masked. The flag stays set until it is cleared, and held flags are accepted one at a time in priority order once they are enabled.
- R6: An event flag clears when its source is accepted, and when `flag_w1c` is high with a 1 in that bit of `flag_mask`. A 0 in the mask leaves the flag unchanged. A new rising edge in the same cycle as a clear leaves the flag set.
- R7: A level source (bit set in parameter `LEVEL_MASK`) has no flag. It requests only while its input is high, so a level that goes away before the source is enabled is never accepted.
- R8: After `cpu_reti`, no source is accepted until `instr_retired` has been high in a later cycle. Acceptance is possible from the cycle after that pulse.
- R9: A source can never be accepted in a cycle with `cli` high, even if the request becomes eligible in that same cycle.
- R10: `irq_addr` equals the base plus twice `irq_index`. The base is 0 when `vec_sel` is 0 and `BOOT_BASE` when it is 1, with `vec_sel` sampled in the cycle the source is accepted.
- R11: `irq_req` is registered. Once it is high, it and `irq_index`/`irq_addr` hold steady until the cycle after `cpu_ack`, and nothing new is accepted while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | NSRC | Interrupt source inputs |
| en_wr | input | 1 | Load the source enable register |
| en_wdata | input | NSRC | New source enable bits |
| flag_w1c | input | 1 | Write-one-to-clear strobe for event flags |
| flag_mask | input | NSRC | Flags to clear (1 = clear) |
| sei | input | 1 | Set global enable |
| cli | input | 1 | Clear global enable, effective this cycle |
| cpu_ack | input | 1 | CPU has taken the vector |
| cpu_reti | input | 1 | CPU executed return-from-interrupt |
| instr_retired | input | 1 | One instruction finished |
| vec_sel | input | 1 | 1 selects boot-section vector base |
| irq_req | output | 1 | Take-interrupt request |
| irq_index | output | IDXW | Vector index of the accepted source |
| irq_addr | output | ADDRW | Vector address of the accepted source |
| gie_o | output | 1 | Global enable state |
| flags_o | output | NSRC | Event flag state |

## Verification
The embedded assertions check on every cycle that a new request appears only when the global enable was set and leaves it cleared. They also check that the chosen source has no eligible lower-index source, that a request holds steady until acknowledged, that nothing is accepted under `cli` or during the post-return hold, and that flags survive unless cleared. Other behaviours need the bench scenarios, where the bench model runs alongside the design. These are the order in which held flags drain across several return cycles, the loss of a level request that vanished while masked, the value of the boot-based address, and the fact that writing zeros to the flag clear leaves state untouched.

// File: rtl/irqv_pkg.sv
// Shared definitions for the vectored interrupt controller.
// Assumes: vector entries are two words apart.
package irqv_pkg;

    // Spacing between consecutive vector entries, in address units.
    localparam int unsigned VEC_STRIDE = 2;

    // Strobes coming from the CPU core and from software writes.
    typedef struct packed {
        logic ack;       // vector taken by the core
        logic reti;      // return-from-interrupt executed
        logic retired;   // one instruction retired
        logic sei;       // set global enable
        logic cli;       // clear global enable
    } cpu_strb_t;

endpackage

// File: rtl/irqv_flags.sv
// Event flag store with rising-edge detection and level pass-through.
// Event sources latch their flag on a rising edge regardless of masking.
// Level sources never hold a flag; their live input is the pending bit.
// Assumes: src_i is already synchronous to clk.
module irqv_flags #(
    parameter int unsigned NSRC = 6,
    parameter logic [NSRC-1:0] LEVEL_MASK = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_i,
    input  logic            w1c_en,
    input  logic [NSRC-1:0] w1c_mask,
    input  logic [NSRC-1:0] take_mask,
    output logic [NSRC-1:0] flags_o,
    output logic [NSRC-1:0] pend_o
);

    logic [NSRC-1:0] src_q;
    logic [NSRC-1:0] flag_q;
    logic [NSRC-1:0] rise;
    logic [NSRC-1:0] clr;

    // Rising edges of event-type sources only.
    assign rise = src_i & ~src_q & ~LEVEL_MASK;
    // Everything that may clear a flag this cycle.
    assign clr  = (w1c_en ? w1c_mask : '0) | take_mask;

    // Remember last input value for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) src_q <= '0;
        else        src_q <= src_i;
    end

    // Flag update: clears first, then a new edge re-sets.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= (flag_q & ~clr) | rise;
    end

    assign flags_o = flag_q;
    assign pend_o  = flag_q | (src_i & LEVEL_MASK);

    // R6: a written-one clear empties the flag unless a new edge arrived.
    a_r6_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        w1c_en |=> ((flag_q & $past(w1c_mask & ~rise)) == '0));

    // R5: a flag with no clear source stays set.
    a_r5_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flag_q & $past(flag_q & ~clr)) == $past(flag_q & ~clr)));

    // R5: a rising edge of an event source always leaves its flag set.
    a_r5_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flag_q & $past(rise)) == $past(rise)));

endmodule

// File: rtl/irqv_prio.sv
// Fixed-priority picker: lowest source number (lowest vector index) wins.
// Produces the winner's vector index (source k -> k+1) and a one-hot mask.
// Assumes: index 0 is reserved for reset and never produced.
module irqv_prio #(
    parameter int unsigned NSRC = 6,
    parameter int unsigned IDXW = 3
) (
    input  logic [NSRC-1:0] elig_i,
    output logic            any_o,
    output logic [IDXW-1:0] idx_o,
    output logic [NSRC-1:0] mask_o
);

    // Scan from the top down so the lowest set bit is the final survivor.
    always_comb begin
        idx_o  = '0;
        mask_o = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (elig_i[i]) begin
                idx_o  = IDXW'(i + 1);
                mask_o = NSRC'(1) << i;
            end
        end
    end

    assign any_o = |elig_i;

    // R3: the winner is eligible and no lower-numbered source is eligible.
    always_comb begin
        if (any_o) begin
            a_r3_lowest_wins: assert ((elig_i & (mask_o - NSRC'(1))) == '0 && (elig_i & mask_o) != '0);
        end
    end

endmodule

// File: rtl/irqv_gate.sv
// Acceptance gate and request register.
// Owns the global enable, the one-instruction hold after a return, and the
// registered request with its index and vector address.
// Assumes: the core pulses ack once per request and reti once per handler.
module irqv_gate
    import irqv_pkg::*;
#(
    parameter int unsigned IDXW = 3,
    parameter int unsigned ADDRW = 14,
    parameter logic [ADDRW-1:0] BOOT_BASE = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cpu_strb_t        strb,
    input  logic             win_any,
    input  logic [IDXW-1:0]  win_idx,
    input  logic             vec_sel,
    output logic             take_o,
    output logic             gie_o,
    output logic             req_o,
    output logic [IDXW-1:0]  idx_o,
    output logic [ADDRW-1:0] addr_o
);

    logic             gie_q;
    logic             hold_q;
    logic             req_q;
    logic [IDXW-1:0]  idx_q;
    logic [ADDRW-1:0] addr_q;
    logic [ADDRW-1:0] base;
    logic [ADDRW-1:0] vec_addr;

    // Accept only with enable set, no disable this cycle, no hold, no open request.
    assign take_o = gie_q & ~strb.cli & ~hold_q & ~req_q & win_any;

    assign base     = vec_sel ? BOOT_BASE : '0;
    assign vec_addr = base + ADDRW'(win_idx) * ADDRW'(VEC_STRIDE);

    // Global enable: acceptance and disable clear, return and enable set.
    always_ff @(posedge clk) begin
        if (!rst_n)                      gie_q <= 1'b0;
        else if (take_o || strb.cli)     gie_q <= 1'b0;
        else if (strb.reti || strb.sei)  gie_q <= 1'b1;
    end

    // Hold after return until one instruction has retired.
    always_ff @(posedge clk) begin
        if (!rst_n)            hold_q <= 1'b0;
        else if (strb.reti)    hold_q <= 1'b1;
        else if (strb.retired) hold_q <= 1'b0;
    end

    // Request register, held until the core acknowledges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q  <= 1'b0;
            idx_q  <= '0;
            addr_q <= '0;
        end else if (take_o) begin
            req_q  <= 1'b1;
            idx_q  <= win_idx;
            addr_q <= vec_addr;
        end else if (strb.ack) begin
            req_q  <= 1'b0;
        end
    end

    assign gie_o  = gie_q;
    assign req_o  = req_q;
    assign idx_o  = idx_q;
    assign addr_o = addr_q;

    // R2: a new request appears only if the global enable was set.
    a_r2_needs_gie: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_q) |-> $past(gie_q));

    // R4: accepting a source leaves the global enable cleared.
    a_r4_take_clears_gie: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_q) |-> !gie_q);

    // R9: a disable strobe blocks acceptance in its own cycle.
    a_r9_cli_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (strb.cli && !req_q) |=> !req_q);

    // R8: while the post-return hold is pending, no request is raised.
    a_r8_hold_after_reti: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_q && !req_q) |=> !req_q);

    // R11: an open request holds with stable index and address until ack.
    a_r11_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (req_q && !strb.ack) |=> (req_q && $stable(idx_q) && $stable(addr_q)));

    // R3: index 0 (reset) is never issued.
    a_r3_no_zero_index: assert property (@(posedge clk) disable iff (!rst_n)
        req_q |-> (idx_q != '0));

endmodule

// File: rtl/irqv_ctrl.sv
// Top of the prioritized vectored interrupt controller.
// Holds the per-source enable register and wires flags, picker and gate.
// Assumes: all inputs are synchronous to clk; software writes are strobes.
module irqv_ctrl
    import irqv_pkg::*;
#(
    parameter int unsigned NSRC = 6,
    parameter int unsigned ADDRW = 14,
    parameter logic [ADDRW-1:0] BOOT_BASE = 14'h3800,
    parameter logic [NSRC-1:0] LEVEL_MASK = 6'b110000,
    localparam int unsigned IDXW = $clog2(NSRC + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  src_i,
    input  logic             en_wr,
    input  logic [NSRC-1:0]  en_wdata,
    input  logic             flag_w1c,
    input  logic [NSRC-1:0]  flag_mask,
    input  logic             sei,
    input  logic             cli,
    input  logic             cpu_ack,
    input  logic             cpu_reti,
    input  logic             instr_retired,
    input  logic             vec_sel,
    output logic             irq_req,
    output logic [IDXW-1:0]  irq_index,
    output logic [ADDRW-1:0] irq_addr,
    output logic             gie_o,
    output logic [NSRC-1:0]  flags_o
);

    logic [NSRC-1:0] en_q;
    logic [NSRC-1:0] pend;
    logic [NSRC-1:0] elig;
    logic [NSRC-1:0] win_mask;
    logic [NSRC-1:0] take_mask;
    logic [IDXW-1:0] win_idx;
    logic            win_any;
    logic            take;
    cpu_strb_t       strb;

    assign strb = '{ack: cpu_ack, reti: cpu_reti, retired: instr_retired, sei: sei, cli: cli};

    // Per-source enable register, loaded whole by software.
    always_ff @(posedge clk) begin
        if (!rst_n)     en_q <= '0;
        else if (en_wr) en_q <= en_wdata;
    end

    assign elig      = pend & en_q;
    assign take_mask = take ? win_mask : '0;

    irqv_flags #(.NSRC(NSRC), .LEVEL_MASK(LEVEL_MASK)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_i     (src_i),
        .w1c_en    (flag_w1c),
        .w1c_mask  (flag_mask),
        .take_mask (take_mask),
        .flags_o   (flags_o),
        .pend_o    (pend)
    );

    irqv_prio #(.NSRC(NSRC), .IDXW(IDXW)) u_prio (
        .elig_i (elig),
        .any_o  (win_any),
        .idx_o  (win_idx),
        .mask_o (win_mask)
    );

    irqv_gate #(.IDXW(IDXW), .ADDRW(ADDRW), .BOOT_BASE(BOOT_BASE)) u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .strb    (strb),
        .win_any (win_any),
        .win_idx (win_idx),
        .vec_sel (vec_sel),
        .take_o  (take),
        .gie_o   (gie_o),
        .req_o   (irq_req),
        .idx_o   (irq_index),
        .addr_o  (irq_addr)
    );

    // R2: the accepted source's enable bit was set when it was accepted.
    a_r2_enabled_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_req) |-> (($past(en_q) >> (irq_index - IDXW'(1))) & NSRC'(1)) != '0);

    // R7: level sources never show a flag.
    a_r7_level_flagless: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_o & LEVEL_MASK) == '0);

endmodule

// File: tb/tb_irqv_ctrl.sv
// Bench for irqv_ctrl: a behavioural model advanced on each rising edge and
// compared on every cycle, plus directed scenario checks per requirement.
module tb_irqv_ctrl;

    localparam int NSRC  = 6;
    localparam int ADDRW = 14;
    localparam int IDXW  = $clog2(NSRC + 1);
    localparam int BOOT  = 'h3800;
    localparam int LVL   = 'b110000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NSRC-1:0] src_i = '0, en_wdata = '0, flag_mask = '0;
    logic en_wr = 0, flag_w1c = 0, sei = 0, cli = 0, cpu_ack = 0, cpu_reti = 0;
    logic instr_retired = 0, vec_sel = 0;
    logic irq_req, gie_o;
    logic [IDXW-1:0] irq_index;
    logic [ADDRW-1:0] irq_addr;
    logic [NSRC-1:0] flags_o;

    int n_cmp = 0, n_bad = 0, cyc = 0;
    bit done = 0;

    always #2 clk = ~clk;  // 4 ns period

    irqv_ctrl dut (.*);

    // ---------------- reference model ----------------
    int m_flags, m_en, m_prev, m_idx, m_addr;
    bit m_gie, m_hold, m_req;

    always @(posedge clk) begin
        int src, pend, elig, win, rise;
        bit take;
        src = int'(src_i);
        if (!rst_n) begin
            m_flags = 0; m_en = 0; m_prev = 0; m_idx = 0; m_addr = 0;
            m_gie = 0; m_hold = 0; m_req = 0;
        end else begin
            rise = src & ~m_prev & ~LVL;
            pend = m_flags | (src & LVL);
            elig = pend & m_en;
            win = 0;
            for (int i = 0; i < NSRC; i++)
                if (win == 0 && elig[i]) win = i + 1;
            take = m_gie && !cli && !m_hold && !m_req && win != 0;
            if (flag_w1c) m_flags = m_flags & ~int'(flag_mask);
            if (take) m_flags = m_flags & ~(1 << (win - 1));
            m_flags = m_flags | rise;
            if (take || cli) m_gie = 0;
            else if (cpu_reti || sei) m_gie = 1;
            if (cpu_reti) m_hold = 1;
            else if (instr_retired) m_hold = 0;
            if (take) begin
                m_req = 1; m_idx = win;
                m_addr = (vec_sel ? BOOT : 0) + 2 * win;
            end else if (cpu_ack) m_req = 0;
            if (en_wr) m_en = int'(en_wdata);
            m_prev = src;
        end
    end

    task automatic chk(bit ok, string rq, int act, int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h (t=%0t)", rq, act, exp, $time);
        end
    endtask

    task automatic compare_model();
        chk(irq_req == m_req, "R11 req", int'(irq_req), int'(m_req));
        chk(gie_o == m_gie, "R4 gie", int'(gie_o), int'(m_gie));
        chk(int'(flags_o) == m_flags, "R5 flags", int'(flags_o), m_flags);
        if (m_req) begin
            chk(int'(irq_index) == m_idx, "R3 index", int'(irq_index), m_idx);
            chk(int'(irq_addr) == m_addr, "R10 addr", int'(irq_addr), m_addr);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
        compare_model();
    endtask

    task automatic steps(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    // One-cycle pulses of the various strobes.
    task automatic pulse_src(int k);
        src_i[k] = 1'b1; step(); src_i[k] = 1'b0; step();
    endtask
    task automatic write_en(int v);
        en_wr = 1; en_wdata = NSRC'(v); step(); en_wr = 0;
    endtask
    task automatic do_sei();  sei = 1; step(); sei = 0; endtask
    task automatic do_ack();  cpu_ack = 1; step(); cpu_ack = 0; endtask
    task automatic do_reti(); cpu_reti = 1; step(); cpu_reti = 0; endtask
    task automatic do_ret1(); instr_retired = 1; step(); instr_retired = 0; endtask
    task automatic do_w1c(int m);
        flag_w1c = 1; flag_mask = NSRC'(m); step(); flag_w1c = 0; flag_mask = '0;
    endtask
    task automatic wait_req(int maxc);
        for (int i = 0; i < maxc && !irq_req; i++) step();
    endtask

    task automatic finish_run();
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            n_bad++; n_cmp++;
            $display("FAIL watchdog: actual %0d expected <20000 cycles", cyc);
            finish_run();
        end
    end

    initial begin
        steps(3);
        // R1: reset state.
        chk(irq_req == 0 && gie_o == 0 && flags_o == 0, "R1 reset", int'({irq_req, gie_o, flags_o}), 0);
        rst_n = 1;
        step();
        chk(irq_req == 0 && gie_o == 0 && flags_o == 0, "R1 after reset", int'({irq_req, gie_o, flags_o}), 0);

        // R2/R10/R4/R6: enabled event source 0 accepted at base 0.
        write_en('b001111);
        do_sei();
        pulse_src(0);
        wait_req(5);
        chk(irq_req == 1 && irq_index == 1, "R2 take idx1", int'(irq_index), 1);
        chk(irq_addr == 2, "R10 base0 addr", int'(irq_addr), 2);
        chk(gie_o == 0, "R4 cleared on take", int'(gie_o), 0);
        chk(flags_o[0] == 0, "R6 cleared on take", int'(flags_o), 0);
        steps(4);
        chk(irq_req == 1 && irq_index == 1, "R11 held until ack", int'(irq_req), 1);
        do_ack(); step();
        chk(irq_req == 0, "R11 ack drops", int'(irq_req), 0);
        do_reti(); do_ret1(); step();

        // R5/R3: flags caught while masked, drained in priority order.
        write_en(0);
        pulse_src(3); pulse_src(1);
        chk(flags_o == 6'b001010, "R5 masked latch", int'(flags_o), 'b001010);
        chk(irq_req == 0, "R2 masked no take", int'(irq_req), 0);
        write_en('b001010);
        wait_req(5);
        chk(irq_req == 1 && irq_index == 2, "R3 lowest first", int'(irq_index), 2);
        do_ack();
        do_reti();
        steps(4);
        chk(irq_req == 0, "R8 hold after reti", int'(irq_req), 0);
        do_ret1();
        wait_req(5);
        chk(irq_req == 1 && irq_index == 4, "R5 next flag served", int'(irq_index), 4);
        do_ack(); do_reti(); do_ret1(); step();

        // R9/R10: cli in the first eligible cycle blocks; boot base.
        write_en('b000001);
        cli = 1; step(); cli = 0;
        pulse_src(0);
        sei = 1; step(); sei = 0;
        cli = 1; step(); cli = 0;
        step();
        chk(irq_req == 0 && gie_o == 0, "R9 cli blocks", int'(irq_req), 0);
        chk(flags_o[0] == 1, "R9 flag kept", int'(flags_o), 1);
        vec_sel = 1;
        do_sei();
        wait_req(5);
        chk(irq_req == 1 && irq_addr == ADDRW'(BOOT + 2), "R10 boot addr", int'(irq_addr), BOOT + 2);
        vec_sel = 0;
        do_ack(); do_reti(); do_ret1(); step();

        // R6: write-zero leaves flag, write-one clears it, edge wins over clear.
        write_en(0);
        pulse_src(2);
        do_w1c(0); step();
        chk(flags_o[2] == 1, "R6 zero no effect", int'(flags_o), 'b100);
        do_w1c('b000100); step();
        chk(flags_o == 0, "R6 one clears", int'(flags_o), 0);
        src_i[2] = 1; step();
        src_i[2] = 0; step();
        src_i[2] = 1; flag_w1c = 1; flag_mask = 'b000100; step();
        flag_w1c = 0; flag_mask = '0; src_i[2] = 0; step();
        chk(flags_o[2] == 1, "R6 edge beats clear", int'(flags_o), 'b100);
        do_w1c('b000100); step();

        // R7: level source lost while masked, accepted while present.
        do_sei();
        src_i[4] = 1; steps(2); src_i[4] = 0; step();
        write_en('b010000); steps(3);
        chk(irq_req == 0 && flags_o == 0, "R7 vanished level", int'(irq_req), 0);
        src_i[4] = 1;
        wait_req(5);
        chk(irq_req == 1 && irq_index == 5, "R7 level taken", int'(irq_index), 5);
        src_i[4] = 0;
        do_ack(); do_reti(); do_ret1(); steps(3);

        finish_run();
    end

endmodule